// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between a clocked host and an asynchronous 128K x 8 static RAM. The host raises a request with a write flag, an address and write data. The block turns that request into a timed sequence on the RAM's control pins and reports completion with a one-clock done pulse. For a read, the data sampled from the RAM bus is returned on a registered output.

The RAM has four control lines:

- a low-true select;
- a high-true select;
- a low-true write strobe;
- a low-true output enable.

The RAM is addressed only while both selects are in their active level. The block keeps the output enable high for the whole of every write, so the data bus never has two drivers. It ends each write by raising the write strobe first, while selects, address and data are still unchanged. Its own data drive is enabled only during a write.

The block has seven states:

- **IDLE**: everything inactive.
- **WSET**: write setup, one cycle with selects, address and data driven.
- **WLOW**: write strobe low for `WR_PULSE` cycles.
- **WEND**: strobe raised while selects, address and data hold for one more cycle; done asserted.
- **RSET**: read setup, one cycle with selects and address driven, strobe and output enable high.
- **RLOW**: output enable low for `RD_WAIT` cycles; the bus is registered on the last one.
- **REND**: output enable raised, selects still active; done asserted.

The transitions are:

- IDLE to WSET when a write request is seen.
- IDLE to RSET when a read request is seen.
- WSET to WLOW.
- WLOW to WEND when the pulse counter expires.
- RSET to RLOW.
- RLOW to REND when the wait counter expires.
- WEND to IDLE.
- REND to IDLE.

Top module: `sram_ctl`

## Requirements
- R1: In reset and in IDLE:
  - the low-true select is 1 and the high-true select is 0;
  - the write strobe and the output enable are 1;
  - the drive enable and done are 0.
- R2: A write request accepted at a clock edge makes the next cycle a setup cycle. In that cycle both selects are active, the address and write data are driven with the drive enable at 1, and the write strobe is still 1.
- R3: The write strobe is low for exactly `WR_PULSE` consecutive cycles per write. This starts in the second cycle after acceptance.
- R4: After the strobe rises there is one cycle in which:
  - both selects stay active;
  - the address and write data are unchanged;
  - the drive enable stays at 1.

  In the following cycle the selects are released and the drive enable goes to 0 together.
- R5: The output enable is 1 in every cycle of a write. The drive enable is 1 only while a write holds the selects active.
- R6: A read consists of one setup cycle, then `RD_WAIT` cycles with the output enable at 0, then one cycle with the output enable back at 1 and the selects still active. Throughout, the write strobe stays 1 and the drive enable stays 0.
- R7: The read data output takes the value on the RAM data bus at the clock edge that ends the last output-enable-low cycle. It keeps that value until the next read completes.
- R8: Done is high for exactly one cycle per transaction. For a write it is the cycle `2+WR_PULSE` after acceptance; for a read it is the cycle `2+RD_WAIT` after acceptance.
- R9: A request is accepted only in IDLE. A request raised during a transaction has no effect: the bus address stays that of the running transaction, and no data is written.
- R10: The memory address does not change in any cycle in which the selects are active and were active in the previous cycle.
- R11: A request held valid continuously is accepted again in the first IDLE cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, low-true |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Registered read data |
| mem_addr | output | 17 | RAM address |
| mem_cs1_n | output | 1 | RAM select, low-true |
| mem_cs2 | output | 1 | RAM select, high-true |
| mem_we_n | output | 1 | RAM write strobe, low-true |
| mem_oe_n | output | 1 | RAM output enable, low-true |
| mem_dout | output | 8 | Data toward the RAM |
| mem_dout_en | output | 1 | Drive enable for mem_dout |
| mem_din | input | 8 | Data sampled from the RAM bus |

## Verification
The bench builds the block with `WR_PULSE=3` and `RD_WAIT=1`. The multi-cycle strobe exercises the counter's countdown path and makes the write length visibly differ from the read length. The single-cycle read wait puts the capture edge at the very first output-enable-low cycle, which is where an off-by-one in the counter would show. The bench's RAM model returns a filler byte whenever its output enable is inactive, so any capture taken at the wrong edge is detected.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WLOW,
        ST_WEND,
        ST_RSET,
        ST_RLOW,
        ST_REND
    } st_e;

    typedef struct packed {
        logic cs1_n;
        logic cs2;
        logic we_n;
        logic oe_n;
        logic drv;
        logic done;
    } pins_t;

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int WR_PULSE = 2,
    parameter int RD_WAIT  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output st_e  state,
    output logic accept,
    output logic capture
);
    localparam int MAXC  = (WR_PULSE > RD_WAIT) ? WR_PULSE : RD_WAIT;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_PULSE - 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_WAIT - 1);

    st_e              state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            state <= state_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        state_d = state;
        cnt_d   = cnt_q;
        unique case (state)
            ST_IDLE: if (req_valid) state_d = req_write ? ST_WSET : ST_RSET;
            ST_WSET: begin
                state_d = ST_WLOW;
                cnt_d   = WR_LOAD;
            end
            ST_WLOW: begin
                if (cnt_q == '0) state_d = ST_WEND;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_WEND: state_d = ST_IDLE;
            ST_RSET: begin
                state_d = ST_RLOW;
                cnt_d   = RD_LOAD;
            end
            ST_RLOW: begin
                if (cnt_q == '0) state_d = ST_REND;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_REND: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign accept  = (state == ST_IDLE) && req_valid;
    assign capture = (state == ST_RLOW) && (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_dec.sv
module sram_ctl_dec
    import sram_ctl_pkg::*;
(
    input  st_e   state,
    output pins_t pins
);
    always_comb begin
        pins = '{cs1_n: 1'b1, cs2: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0, done: 1'b0};
        unique case (state)
            ST_IDLE: ;
            ST_WSET: pins = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b1, done: 1'b0};
            ST_WLOW: pins = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b0, oe_n: 1'b1, drv: 1'b1, done: 1'b0};
            ST_WEND: pins = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b1, done: 1'b1};
            ST_RSET: pins = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0, done: 1'b0};
            ST_RLOW: pins = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b1, oe_n: 1'b0, drv: 1'b0, done: 1'b0};
            ST_REND: pins = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0, done: 1'b1};
            default: ;
        endcase
    end
endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] bus_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (capture) rdata_q <= bus_in;
    end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW       = 17,
    parameter int DW       = 8,
    parameter int WR_PULSE = 2,
    parameter int RD_WAIT  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs1_n,
    output logic          mem_cs2,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dout,
    output logic          mem_dout_en,
    input  logic [DW-1:0] mem_din
);
    st_e   state;
    logic  accept, capture;
    pins_t pins;

    sram_ctl_seq #(.WR_PULSE(WR_PULSE), .RD_WAIT(RD_WAIT)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .state    (state),
        .accept   (accept),
        .capture  (capture)
    );

    sram_ctl_dec u_dec (
        .state(state),
        .pins (pins)
    );

    sram_ctl_dp #(.AW(AW), .DW(DW)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .capture  (capture),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .bus_in   (mem_din),
        .addr_q   (mem_addr),
        .wdata_q  (mem_dout),
        .rdata_q  (rdata)
    );

    assign mem_cs1_n   = pins.cs1_n;
    assign mem_cs2     = pins.cs2;
    assign mem_we_n    = pins.we_n;
    assign mem_oe_n    = pins.oe_n;
    assign mem_dout_en = pins.drv;
    assign done        = pins.done;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic [AW-1:0] mem_addr,
    input logic          mem_cs1_n,
    input logic          mem_cs2,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic [DW-1:0] mem_dout,
    input logic          mem_dout_en
);
    logic sel;
    assign sel = !mem_cs1_n && mem_cs2;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (mem_we_n && mem_oe_n && !mem_dout_en && !done));

    // R2
    strobe_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(sel) && $past(mem_dout_en) && sel));

    // R4
    strobe_release_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (sel && mem_dout_en && $stable(mem_addr) && $stable(mem_dout)));

    // R5
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> (mem_oe_n && sel));

    // R10
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $past(sel)) |-> $stable(mem_addr));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .mem_addr   (mem_addr),
    .mem_cs1_n  (mem_cs1_n),
    .mem_cs2    (mem_cs2),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dout   (mem_dout),
    .mem_dout_en(mem_dout_en)
);

// File: tb/sram_ctl_test.sv
module sram_ctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WRP = 3;
    localparam int RDW = 1;
    localparam int WLEN = 2 + WRP;
    localparam int RLEN = 2 + RDW;
    localparam logic [7:0] FILLER = 8'hEE;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, req_write = 0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        done, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dout_en;
    logic [7:0]  rdata, mem_dout;
    logic [7:0]  mem_din = FILLER;
    logic [16:0] mem_addr;

    int errors = 0, checks = 0, cycles = 0;

    sram_ctl #(.WR_PULSE(WRP), .RD_WAIT(RDW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .mem_din(mem_din)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural RAM: written on the rising strobe, read data valid half a cycle after oe falls
    logic [7:0] ram [logic [16:0]];
    always @(posedge mem_we_n)
        if (rst_n && !mem_cs1_n && mem_cs2 && mem_dout_en) ram[mem_addr] = mem_dout;
    always @(negedge clk)
        mem_din <= (!mem_cs1_n && mem_cs2 && mem_we_n && !mem_oe_n)
                   ? (ram.exists(mem_addr) ? ram[mem_addr] : 8'h00) : FILLER;

    // reference model
    int          m_t = 0;
    bit          m_wr;
    logic [16:0] m_addr;
    logic [7:0]  m_wd, m_rdata = 8'h00;
    logic [7:0]  ref_mem [logic [16:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_t = 0; m_rdata = 8'h00;
        end else if (m_t == 0) begin
            if (req_valid) begin
                m_t = 1; m_wr = req_write; m_addr = req_addr; m_wd = req_wdata;
            end
        end else begin
            int len;
            len = m_wr ? WLEN : RLEN;
            if (m_t == len) m_t = 0;
            else begin
                m_t++;
                if (m_t == len) begin
                    if (m_wr) ref_mem[m_addr] = m_wd;
                    else m_rdata = ref_mem.exists(m_addr) ? ref_mem[m_addr] : 8'h00;
                end
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d act=%h exp=%h", req, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > 2) begin
            if (m_t == 0) begin
                // R1
                check("R1 pins", {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dout_en, done}, 6'b101100);
            end else if (m_wr) begin
                // R2 R3 R4 R5 R8
                check("R3/R5 write pins", {mem_cs1_n, mem_cs2, mem_oe_n, mem_dout_en}, 4'b0111);
                check("R3 strobe", mem_we_n, !(m_t >= 2 && m_t <= 1 + WRP));
                check("R8 write done", done, m_t == WLEN);
                check("R2 wdata", mem_dout, m_wd);
                check("R10 waddr", mem_addr, m_addr);
            end else begin
                // R6 R8
                check("R6 read pins", {mem_cs1_n, mem_cs2, mem_we_n, mem_dout_en}, 4'b0110);
                check("R6 oe", mem_oe_n, !(m_t >= 2 && m_t <= 1 + RDW));
                check("R8 read done", done, m_t == RLEN);
                check("R9 raddr", mem_addr, m_addr);
            end
            // R7
            check("R7 rdata", rdata, m_rdata);
        end
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (m_t != 0) @(negedge clk);
    endtask

    task automatic issue(bit w, logic [16:0] a, logic [7:0] d);
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        while (m_t != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2 R3 R4: corner addresses and data
        issue(1, 17'h00000, 8'h5A);
        issue(1, 17'h1FFFF, 8'hFF);
        issue(1, 17'h0A5A5, 8'h00);
        issue(1, 17'h12345, 8'hC3);
        // R7: read back
        issue(0, 17'h00000, 8'h00);
        issue(0, 17'h1FFFF, 8'h00);
        issue(0, 17'h0A5A5, 8'h00);
        issue(0, 17'h12345, 8'h00);
        // R9: request while busy has no effect
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 17'h00100; req_wdata = 8'h11;
        @(negedge clk);
        req_addr = 17'h12345; req_wdata = 8'h99;
        @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        wait_idle();
        issue(0, 17'h12345, 8'h00);
        issue(0, 17'h00100, 8'h00);
        // R11: held request, back to back reads then writes
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 17'h1FFFF;
        repeat (3 * RLEN + 2) @(negedge clk);
        req_write = 1; req_addr = 17'h00042; req_wdata = 8'h24;
        repeat (2 * WLEN + 1) @(negedge clk);
        req_valid = 0;
        wait_idle();
        issue(0, 17'h00042, 8'h00);
        // overwrite then read
        issue(1, 17'h00042, 8'h7E);
        issue(0, 17'h00042, 8'h00);
        // R1 reset mid-transaction
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 17'h00007; req_wdata = 8'h01;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule